// File: doc/BRIEF.md
# Bus channel selector with interrupt aggregation

This block holds the control register of a four-way downstream bus switch and gathers the interrupt lines of the four downstream segments. A host writes one byte through a strobed register port. An enable flag and a two-bit index in that byte choose at most one downstream channel, and the block drives that choice as a one-hot enable vector for the pass switches.

Each channel has an active-low interrupt input. All four inputs pass through a two-flop synchronizer. The block merges them into one active-low line, which it models as an open-drain pull-down enable. A register read captures the four synchronized levels into the upper nibble of the returned byte, so the host can see which segment is calling. This works whichever channel is routed. The block keeps no sticky interrupt state: the merged line follows the inputs.

Top module: `chansel_irq`

## Requirements
- R1: When register bit 2 (enable) is 0, `chan_en` is 4'b0000, whatever bits 1:0 hold. The change takes effect in the cycle after the write strobe.
- R2: When bit 2 is 1, bits 1:0 give the index i, and `chan_en` equals 1 << i (index 0 drives bit 0, index 3 drives bit 3). The change takes effect in the cycle after the write strobe.
- R3: `chan_en` is always one-hot or all zero.
- R4: After synchronous reset the register is 0x00, `chan_en` is 0 and `irq_pull` is 0. With no interrupt pending, the first read returns 0x00.
- R5: A read returns bit 4+i = 1 exactly when `irq_n_in[i]` is low. This holds when the input has been stable for at least two cycles before the strobe. It does not depend on the selected channel, and several bits may be 1 in one value.
- R6: `irq_pull` is 1 exactly when any `irq_n_in` bit was low two clock edges earlier. It stays 1 until every asserting input has gone high, and it does not depend on the selected channel.
- R7: Bit 3 always reads 0. Writes change only bits 2:0, so written values of bits 7:3 have no effect.
- R8: `rd_data` loads in the cycle after `rd_en`. Its bits 2:0 hold the register value at the strobe, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read byte, loaded on the cycle after `rd_en` |
| chan_en | output | 4 | One-hot downstream channel enable |
| irq_n_in | input | 4 | Per-channel active-low interrupt inputs |
| irq_pull | output | 1 | High when the merged interrupt line is pulled low |

## Verification
The hardest case to reach is a channel that stays in interrupt while a different channel is routed. The case needs overlapping sources that release one at a time, and that must be seen both on the merged line and in a captured read. The stimulus routes channel 0 and asserts channels 1 and 2 together. It then releases them one after the other, reading and sampling `irq_pull` after each step. A further step writes ones into the read-only nibble while channel 3 is asserting, and checks that only the live input appears in the read.

// File: rtl/chansel_pkg.sv
package chansel_pkg;
    localparam int N_CH    = 4;
    localparam int IDX_W   = $clog2(N_CH);
    localparam int DATA_W  = 8;
    localparam int EN_BIT  = IDX_W;
    localparam int IRQ_LSB = DATA_W - N_CH;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } sel_t;

    function automatic logic [N_CH-1:0] decode_sel(input sel_t s);
        logic [N_CH-1:0] v;
        v = '0;
        if (s.en) v[s.idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/chansel_sync.sv
module chansel_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '1;
                else if (s == 0) stage_q[s] <= din;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (STAGES == 2 && since_rst >= 2'd2) |-> dout == $past(din, 2));
endmodule

// File: rtl/chansel_regs.sv
module chansel_regs
    import chansel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [N_CH-1:0]   irq_act,
    output sel_t              sel,
    output logic [DATA_W-1:0] rd_data
);
    sel_t sel_q;
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en) begin
            sel_q.en  <= wr_data[EN_BIT];
            sel_q.idx <= wr_data[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q                     <= '0;
            rd_q[DATA_W-1:IRQ_LSB]   <= irq_act;
            rd_q[EN_BIT:0]           <= sel_q;
        end
    end

    assign sel     = sel_q;
    assign rd_data = rd_q;

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_data[IRQ_LSB-1:EN_BIT+1] == '0);
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    // R8
    rd_low_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_data[EN_BIT:0] == $past(sel_q));
endmodule

// File: rtl/chansel_irq.sv
module chansel_irq
    import chansel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_CH-1:0]   chan_en,
    input  logic [N_CH-1:0]   irq_n_in,
    output logic              irq_pull
);
    logic [N_CH-1:0] irq_n_sync;
    logic [N_CH-1:0] irq_act;
    sel_t            sel;

    chansel_sync #(.W(N_CH), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (irq_n_in),
        .dout(irq_n_sync)
    );

    assign irq_act  = ~irq_n_sync;
    assign irq_pull = |irq_act;

    chansel_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .irq_act(irq_act),
        .sel    (sel),
        .rd_data(rd_data)
    );

    assign chan_en = decode_sel(sel);

    // R3
    chan_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_en));
    // R1
    chan_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[EN_BIT]) |=> chan_en == '0);
    // R2
    chan_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[EN_BIT]) |=> chan_en == (N_CH'(1) << $past(wr_data[IDX_W-1:0])));
    // R4
    reset_idle_chk: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (chan_en == '0 && !irq_pull && rd_data == '0));
endmodule

// File: tb/chansel_irq_bench.sv
module chansel_irq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [3:0] chan_en;
    logic [3:0] irq_n_in;
    logic       irq_pull;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chansel_irq u_chansel_irq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .chan_en(chan_en),
        .irq_n_in(irq_n_in), .irq_pull(irq_pull)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // monitor: pops the expected read value one cycle after each strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en === 1'b1) begin
                @(negedge clk);
                if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
                else check("R8 unexpected read", rd_data, 8'hxx);
            end
        end
    end

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_read(input string req, input logic [7:0] exp);
        exp_q.push_back(exp); tag_q.push_back(req);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_irq(input logic [3:0] v);
        irq_n_in = v;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            if (exp_q.size() != 0) check("R8 reads pending", 8'(exp_q.size()), 8'h00);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; wr_data = '0; irq_n_in = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R4 chan_en after reset", {4'h0, chan_en}, 8'h00);
        check("R4 irq_pull after reset", {7'h0, irq_pull}, 8'h00);
        do_read("R4 reset read", 8'h00);

        for (int i = 0; i < 4; i++) begin
            do_write(8'h04 | 8'(i));
            check("R2 R3 channel decode", {4'h0, chan_en}, 8'(1 << i));
            do_read("R8 register readback", 8'h04 | 8'(i));
        end

        do_write(8'h03);
        check("R1 enable clear", {4'h0, chan_en}, 8'h00);
        do_write(8'hFB);
        check("R1 R7 upper write, enable clear", {4'h0, chan_en}, 8'h00);
        do_read("R7 upper and bit3 write ignored", 8'h03);
        do_write(8'h0D);
        check("R7 bit3 ignored, channel 1", {4'h0, chan_en}, 8'h02);
        do_read("R7 bit3 reads zero", 8'h05);

        do_write(8'h04);
        irq_n_in = 4'b1101;
        @(negedge clk);
        check("R6 one edge latency", {7'h0, irq_pull}, 8'h00);
        @(negedge clk);
        check("R6 unselected channel asserts", {7'h0, irq_pull}, 8'h01);
        do_read("R5 channel 1 bit", 8'h24);
        set_irq(4'b1001);
        do_read("R5 two interrupt bits", 8'h64);
        set_irq(4'b1011);
        check("R6 held by remaining source", {7'h0, irq_pull}, 8'h01);
        do_read("R5 partial release", 8'h44);
        set_irq(4'b1111);
        check("R6 release", {7'h0, irq_pull}, 8'h00);
        do_read("R5 all released", 8'h04);
        set_irq(4'b0000);
        check("R8 hold without read", rd_data, 8'h04);
        check("R6 all asserted", {7'h0, irq_pull}, 8'h01);
        do_read("R5 all four bits", 8'hF4);
        set_irq(4'b0111);
        do_write(8'hF6);
        check("R2 channel 2 during interrupt", {4'h0, chan_en}, 8'h04);
        do_read("R7 upper nibble read-only", 8'h86);
        set_irq(4'b1111);
        do_read("R5 cleared", 8'h06);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule